// File: doc/BRIEF.md
# Memory-Backed Multi-Channel Event Counter

This block counts edge events on sixteen input lines. It does not keep a counter register per line. Each count is a 16-bit word in a small on-block word memory. Every line passes through a two-flop synchronizer and an edge detector. A control bit selects rising or falling edges for all lines. A detected edge latches a per-line pending flag.

While any flag is set, the block raises one shared request. One transfer engine services the pending lines one at a time, lowest line number first. For each line it forms a word address from a table base and the line's code, reads the count, adds one and writes the result back to the same address.

A host port gives access to two control registers and to the whole word memory. The host uses it to enable counting, pick the edge and the table base, watch the pending flags, and preset or read back any count.

Top module: `evc_event_counter`

## Requirements
- R1: After synchronous reset, all pending flags are 0, the control register reads 0, `busy` is 0 and `evt_req` is 0.
- R2: Each event line is passed through two synchronizing flops before edge detection. A rising edge sets the line's flag when control bit 2 is 0, and a falling edge sets it when control bit 2 is 1. The flag is set on the third rising clock edge after the input changes.
- R3: `evt_req` is 1 exactly when at least one pending flag is 1.
- R4: A read-increment-write sequence starts from idle on a clock edge where control bits 0 and 1 are both 1, at least one flag is set and `host_en` is 0. It then holds `busy` high for exactly three cycles.
- R5: The count of line n lives at byte address base*32 + 2n, where base is control bits 7:5. The base is sampled when the sequence starts. A sequence writes the value read plus one to that same word, and 0xFFFF wraps to 0x0000.
- R6: When several flags are pending, the sequence services the lowest-numbered line first.
- R7: A line's flag clears when its write completes. An edge on that line detected in the same cycle keeps the flag set, so no event is lost.
- R8: When `host_space` is 1 and `busy` is 0, a host read returns the word at `host_addr[7:1]` on `host_rdata` in the following cycle, and a host write stores `host_wdata` there. A host memory write issued while `busy` is 1 is ignored.
- R9: With `host_space` 0, byte address 0 is the control register and byte address 2 is the read-only pending-flag register (bit n = line n). A read returns the value in the next cycle. Control bits 0 (count enable), 1 (transfer enable), 2 (falling-edge select) and 7:5 (base) are writable, and the other bits read as 0.
- R10: With control bit 0 clear, edges set no flag. With bit 1 clear, set flags stay pending and no sequence starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_in | input | 16 | Asynchronous event lines |
| host_en | input | 1 | Host access strobe |
| host_we | input | 1 | 1 = write, 0 = read |
| host_space | input | 1 | 0 = registers, 1 = count memory |
| host_addr | input | 8 | Byte address |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Read data, valid the cycle after a read |
| busy | output | 1 | Read-increment-write sequence in progress |
| evt_req | output | 1 | At least one pending flag set |

## Verification
Two things can coincide. A new edge can be detected on the same line, in the same cycle, that the engine's write clears its flag. And a host access can fall on the edge where the engine would otherwise start. The bench toggles one line every two cycles so that its edges fall inside its own transfers. It also issues host reads and writes just as flags become pending and during a transfer. A behavioural model compares `busy` and `evt_req` on every clock, and the final memory readback shows whether any event was lost or counted twice.

// File: rtl/evc_pkg.sv
package evc_pkg;
    localparam int EVC_CH      = 16;
    localparam int EVC_CNT_W   = 16;
    localparam int EVC_ADDR_W  = 8;
    localparam int EVC_IDX_W   = $clog2(EVC_CH);
    localparam int EVC_CODE_W  = EVC_IDX_W + 1;
    localparam int EVC_BASE_W  = EVC_ADDR_W - EVC_CODE_W;
    localparam int EVC_WORD_AW = EVC_ADDR_W - 1;

    typedef enum logic [1:0] {
        ENG_IDLE  = 2'd0,
        ENG_READ  = 2'd1,
        ENG_BUMP  = 2'd2,
        ENG_WRITE = 2'd3
    } eng_state_e;

    typedef struct packed {
        logic [EVC_BASE_W-1:0] base;
        logic [1:0]            rsvd;
        logic                  edge_fall;
        logic                  xfer_en;
        logic                  cnt_en;
    } evc_ctrl_t;

    typedef struct packed {
        logic [EVC_IDX_W-1:0]   ch;
        logic [EVC_WORD_AW-1:0] waddr;
    } evc_job_t;

    function automatic logic [EVC_IDX_W-1:0] lowest_set(input logic [EVC_CH-1:0] v);
        logic [EVC_IDX_W-1:0] r;
        r = '0;
        for (int i = EVC_CH - 1; i >= 0; i--) begin
            if (v[i]) r = EVC_IDX_W'(i);
        end
        return r;
    endfunction

    function automatic logic [EVC_WORD_AW-1:0] table_word(input logic [EVC_BASE_W-1:0] b,
                                                          input logic [EVC_IDX_W-1:0] idx);
        return {b, idx};
    endfunction
endpackage

// File: rtl/evc_edge_detect.sv
module evc_edge_detect #(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] raw_in,
    input  logic         fall_mode,
    input  logic         enable,
    output logic [N-1:0] hit
);
    for (genvar g = 0; g < N; g++) begin : g_line
        logic meta_q, sync_q, last_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                meta_q <= 1'b0;
                sync_q <= 1'b0;
                last_q <= 1'b0;
            end else begin
                meta_q <= raw_in[g];
                sync_q <= meta_q;
                last_q <= sync_q;
            end
        end
        always_comb begin
            if (fall_mode) hit[g] = enable & ~sync_q & last_q;
            else           hit[g] = enable & sync_q & ~last_q;
        end
    end
endmodule

// File: rtl/evc_flag_bank.sv
module evc_flag_bank #(
    parameter int N     = 16,
    parameter int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N-1:0]     set_vec,
    input  logic             clr_en,
    input  logic [IDX_W-1:0] clr_idx,
    output logic [N-1:0]     flags
);
    logic [N-1:0] clr_vec;

    always_comb begin
        clr_vec = '0;
        if (clr_en) clr_vec[clr_idx] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) flags <= '0;
        else     flags <= (flags & ~clr_vec) | set_vec;
    end
endmodule

// File: rtl/evc_word_mem.sv
module evc_word_mem #(
    parameter int AW = 7,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic [AW-1:0] addr,
    input  logic          re,
    input  logic          we,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;
    logic [DW-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) store[addr] <= wdata;
        if (re) rdata <= store[addr];
    end
endmodule

// File: rtl/evc_rmw_engine.sv
module evc_rmw_engine
    import evc_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   go,
    input  logic [EVC_CH-1:0]      flags,
    input  logic [EVC_BASE_W-1:0]  base,
    input  logic [EVC_CNT_W-1:0]   mem_rdata,
    output eng_state_e             state,
    output logic                   busy,
    output logic [EVC_IDX_W-1:0]   cur_ch,
    output logic                   clr_en,
    output logic [EVC_WORD_AW-1:0] mem_addr,
    output logic                   mem_re,
    output logic                   mem_we,
    output logic [EVC_CNT_W-1:0]   mem_wdata
);
    evc_job_t              job_q;
    logic [EVC_CNT_W-1:0]  sum_q;
    logic [EVC_IDX_W-1:0]  pick;

    assign pick = lowest_set(flags);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ENG_IDLE;
            job_q <= '0;
            sum_q <= '0;
        end else begin
            unique case (state)
                ENG_IDLE: begin
                    if (go && (flags != '0)) begin
                        job_q.ch    <= pick;
                        job_q.waddr <= table_word(base, pick);
                        state       <= ENG_READ;
                    end
                end
                ENG_READ:  state <= ENG_BUMP;
                ENG_BUMP: begin
                    sum_q <= mem_rdata + EVC_CNT_W'(1);
                    state <= ENG_WRITE;
                end
                ENG_WRITE: state <= ENG_IDLE;
                default:   state <= ENG_IDLE;
            endcase
        end
    end

    assign busy      = (state != ENG_IDLE);
    assign cur_ch    = job_q.ch;
    assign mem_addr  = job_q.waddr;
    assign mem_re    = (state == ENG_READ);
    assign mem_we    = (state == ENG_WRITE);
    assign clr_en    = (state == ENG_WRITE);
    assign mem_wdata = sum_q;
endmodule

// File: rtl/evc_event_counter.sv
module evc_event_counter
    import evc_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [EVC_CH-1:0]     evt_in,
    input  logic                  host_en,
    input  logic                  host_we,
    input  logic                  host_space,
    input  logic [EVC_ADDR_W-1:0] host_addr,
    input  logic [EVC_CNT_W-1:0]  host_wdata,
    output logic [EVC_CNT_W-1:0]  host_rdata,
    output logic                  busy,
    output logic                  evt_req
);
    evc_ctrl_t              ctrl_q;
    logic [EVC_CH-1:0]      hits;
    logic [EVC_CH-1:0]      flags;
    eng_state_e             eng_state;
    logic                   eng_clr;
    logic [EVC_IDX_W-1:0]   eng_ch;
    logic [EVC_WORD_AW-1:0] eng_addr;
    logic                   eng_re, eng_we;
    logic [EVC_CNT_W-1:0]   eng_wdata;
    logic                   eng_go;

    logic [EVC_WORD_AW-1:0] mem_addr;
    logic                   mem_re, mem_we;
    logic [EVC_CNT_W-1:0]   mem_wdata, mem_rdata;

    logic                   host_mem_ok, host_reg_acc;
    logic                   rd_src_mem_q;
    logic [EVC_CNT_W-1:0]   reg_rd_q;

    evc_edge_detect #(.N(EVC_CH)) u_edge (
        .clk(clk), .rst(rst), .raw_in(evt_in),
        .fall_mode(ctrl_q.edge_fall), .enable(ctrl_q.cnt_en), .hit(hits)
    );

    evc_flag_bank #(.N(EVC_CH), .IDX_W(EVC_IDX_W)) u_flags (
        .clk(clk), .rst(rst), .set_vec(hits),
        .clr_en(eng_clr), .clr_idx(eng_ch), .flags(flags)
    );

    assign eng_go = ctrl_q.cnt_en & ctrl_q.xfer_en & ~host_en;

    evc_rmw_engine u_eng (
        .clk(clk), .rst(rst), .go(eng_go), .flags(flags), .base(ctrl_q.base),
        .mem_rdata(mem_rdata), .state(eng_state), .busy(busy), .cur_ch(eng_ch),
        .clr_en(eng_clr), .mem_addr(eng_addr), .mem_re(eng_re), .mem_we(eng_we),
        .mem_wdata(eng_wdata)
    );

    assign host_mem_ok  = host_en & host_space & ~busy;
    assign host_reg_acc = host_en & ~host_space;

    always_comb begin
        if (busy) begin
            mem_addr  = eng_addr;
            mem_re    = eng_re;
            mem_we    = eng_we;
            mem_wdata = eng_wdata;
        end else begin
            mem_addr  = host_addr[EVC_ADDR_W-1:1];
            mem_re    = host_mem_ok & ~host_we;
            mem_we    = host_mem_ok & host_we;
            mem_wdata = host_wdata;
        end
    end

    evc_word_mem #(.AW(EVC_WORD_AW), .DW(EVC_CNT_W)) u_mem (
        .clk(clk), .addr(mem_addr), .re(mem_re), .we(mem_we),
        .wdata(mem_wdata), .rdata(mem_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q       <= '0;
            reg_rd_q     <= '0;
            rd_src_mem_q <= 1'b0;
        end else begin
            if (host_reg_acc && host_we && !host_addr[1]) begin
                ctrl_q.base      <= host_wdata[7:5];
                ctrl_q.rsvd      <= 2'b00;
                ctrl_q.edge_fall <= host_wdata[2];
                ctrl_q.xfer_en   <= host_wdata[1];
                ctrl_q.cnt_en    <= host_wdata[0];
            end
            if (host_reg_acc && !host_we) begin
                rd_src_mem_q <= 1'b0;
                reg_rd_q     <= host_addr[1] ? EVC_CNT_W'(flags) : EVC_CNT_W'(ctrl_q);
            end else if (host_mem_ok && !host_we) begin
                rd_src_mem_q <= 1'b1;
            end
        end
    end

    assign host_rdata = rd_src_mem_q ? mem_rdata : reg_rd_q;
    assign evt_req    = |flags;
endmodule

// File: rtl/evc_event_counter_chk.sv
module evc_event_counter_chk
    import evc_pkg::*;
(
    input logic                   clk,
    input logic                   rst,
    input logic                   busy,
    input logic                   evt_req,
    input logic                   host_en,
    input evc_ctrl_t              ctrl_q,
    input eng_state_e             eng_state,
    input logic [EVC_CH-1:0]      flags,
    input logic [EVC_IDX_W-1:0]   eng_ch,
    input logic                   mem_we,
    input logic [EVC_WORD_AW-1:0] mem_addr,
    input logic [EVC_CNT_W-1:0]   mem_wdata,
    input logic [EVC_CNT_W-1:0]   mem_rdata
);
    logic [EVC_CH-1:0] below_mask;
    assign below_mask = (EVC_CH'(1) << eng_ch) - EVC_CH'(1);

    p_busy_span_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |=> busy ##1 busy ##1 !busy);

    p_start_gate_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(ctrl_q.cnt_en && ctrl_q.xfer_en && !host_en));

    p_busy_has_req_r3: assert property (@(posedge clk) disable iff (rst)
        busy |-> evt_req);

    p_inc_value_r5: assert property (@(posedge clk) disable iff (rst)
        (eng_state == ENG_WRITE) |-> (mem_wdata == EVC_CNT_W'(mem_rdata + EVC_CNT_W'(1))));

    p_same_word_r5: assert property (@(posedge clk) disable iff (rst)
        (eng_state == ENG_WRITE) |-> (mem_addr == $past(mem_addr, 2)));

    p_pick_lowest_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> ((($past(flags) >> eng_ch) & EVC_CH'(1)) == EVC_CH'(1))
                        && (($past(flags) & below_mask) == '0));

    p_busy_write_src_r8: assert property (@(posedge clk) disable iff (rst)
        (busy && mem_we) |-> (eng_state == ENG_WRITE));
endmodule

bind evc_event_counter evc_event_counter_chk u_chk (
    .clk(clk), .rst(rst), .busy(busy), .evt_req(evt_req), .host_en(host_en),
    .ctrl_q(ctrl_q), .eng_state(eng_state), .flags(flags), .eng_ch(eng_ch),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
);

// File: tb/evc_event_counter_tb.sv
module evc_event_counter_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] evt_in = '0;
    logic        host_en = 1'b0, host_we = 1'b0, host_space = 1'b0;
    logic [7:0]  host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        busy, evt_req;

    int n_run = 0, n_fail = 0, cyc = 0;
    bit done = 0;

    always #4 clk = ~clk;

    evc_event_counter u_dut (
        .clk(clk), .rst(rst), .evt_in(evt_in), .host_en(host_en), .host_we(host_we),
        .host_space(host_space), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .busy(busy), .evt_req(evt_req)
    );

    // behavioural reference
    logic [15:0] m_d1, m_d2, m_d3, m_flags, m_rdata;
    logic [7:0]  m_ctrl;
    logic [15:0] m_mem [128];
    int          m_phase, m_ch, m_waddr;

    always @(posedge clk) begin
        if (rst) begin
            m_d1 = '0; m_d2 = '0; m_d3 = '0; m_flags = '0; m_rdata = '0;
            m_ctrl = '0; m_phase = 0; m_ch = 0; m_waddr = 0;
        end else begin
            logic [15:0] edges, clr;
            logic [7:0]  nctrl;
            int          ph0;
            ph0   = m_phase;
            edges = m_ctrl[2] ? (m_d3 & ~m_d2) : (m_d2 & ~m_d3);
            if (!m_ctrl[0]) edges = '0;
            clr   = '0;
            nctrl = m_ctrl;
            case (ph0)
                0: if (m_ctrl[0] && m_ctrl[1] && m_flags != 0 && !host_en) begin
                       for (int i = 15; i >= 0; i--) if (m_flags[i]) m_ch = i;
                       m_waddr = int'(m_ctrl[7:5]) * 16 + m_ch;
                       m_phase = 1;
                   end
                1: m_phase = 2;
                2: m_phase = 3;
                default: begin
                    m_mem[m_waddr] = m_mem[m_waddr] + 16'd1;
                    clr[m_ch] = 1'b1;
                    m_phase = 0;
                end
            endcase
            if (host_en && !host_space) begin
                if (host_we && !host_addr[1]) nctrl = {host_wdata[7:5], 2'b00, host_wdata[2:0]};
                if (!host_we) m_rdata = host_addr[1] ? m_flags : {8'h00, m_ctrl};
            end else if (host_en && host_space && ph0 == 0) begin
                if (host_we) m_mem[host_addr[7:1]] = host_wdata;
                else         m_rdata = m_mem[host_addr[7:1]];
            end
            m_flags = (m_flags & ~clr) | edges;
            m_d3 = m_d2; m_d2 = m_d1; m_d1 = evt_in;
            m_ctrl = nctrl;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // per-clock comparison (R3, R4)
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk(busy == (m_phase != 0), "R4 busy", 16'(busy), 16'(m_phase != 0));
            chk(evt_req == (m_flags != 0), "R3 evt_req", 16'(evt_req), 16'(m_flags != 0));
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1;
            n_run++; n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    task automatic wait_idle();
        while (m_phase != 0) @(negedge clk);
    endtask

    task automatic hwrite(input bit sp, input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        if (sp) wait_idle();
        host_en = 1; host_we = 1; host_space = sp; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_en = 0; host_we = 0;
    endtask

    task automatic hread(input bit sp, input logic [7:0] a, input string req);
        @(negedge clk);
        if (sp) wait_idle();
        host_en = 1; host_we = 0; host_space = sp; host_addr = a;
        @(negedge clk);
        host_en = 0;
        chk(host_rdata === m_rdata, req, host_rdata, m_rdata);
    endtask

    task automatic pulse(input logic [15:0] mask, input int hold);
        @(negedge clk);
        evt_in = evt_in ^ mask;
        repeat (hold) @(negedge clk);
        evt_in = evt_in ^ mask;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        chk(busy == 0 && evt_req == 0, "R1 outputs", {busy, evt_req}, 16'h0);
        hread(0, 8'd0, "R1 ctrl");
        hread(0, 8'd2, "R1 flags");

        // R8 preset whole memory
        for (int w = 0; w < 128; w++) hwrite(1, 8'(w * 2), 16'(w * 3 + 1));
        hread(1, 8'd14, "R8 read");

        // R10 counting disabled: no flag
        pulse(16'h0008, 2); idle(6);
        hread(0, 8'd2, "R10 no flag when count off");

        // R9 control layout, reserved bits read 0
        hwrite(0, 8'd0, 16'hFF19);
        hread(0, 8'd0, "R9 ctrl bits");
        hwrite(0, 8'd0, 16'h0001);

        // R10 count on, transfer off: flag stays
        pulse(16'h0008, 2); idle(8);
        hread(0, 8'd2, "R10 flag pending");
        hread(0, 8'd2, "R2 rising edge flag");

        // R4 R5 enable transfers
        hwrite(0, 8'd0, 16'h0003);
        idle(8);
        hread(1, 8'd6, "R5 ch3 incremented");
        hread(0, 8'd2, "R7 flag cleared");

        // R6 several at once, peek flags while servicing
        pulse(16'h8421, 2);
        idle(4);
        hread(0, 8'd2, "R6 flags mid-service");
        idle(3);
        hread(0, 8'd2, "R6 flags later");
        idle(20);
        hread(1, 8'd0,  "R6 ch0 count");
        hread(1, 8'd30, "R6 ch15 count");

        // R2 falling-edge mode
        hwrite(0, 8'd0, 16'h0007);
        pulse(16'h0010, 3); idle(20);
        hread(1, 8'd8, "R2 falling edge counted once");
        hwrite(0, 8'd0, 16'h0003);

        // R7 edges on a line during its own transfers
        for (int k = 0; k < 24; k++) begin
            @(negedge clk); evt_in[5] = ~evt_in[5];
            @(negedge clk);
        end
        evt_in[5] = 1'b0;
        idle(60);
        hread(1, 8'd10, "R7 no lost edge");
        hread(0, 8'd2, "R7 drained");

        // R5 wrap
        hwrite(1, 8'd14, 16'hFFFF);
        pulse(16'h0080, 2); idle(12);
        hread(1, 8'd14, "R5 wrap to zero");

        // R5 base change: base 2 -> word 47
        hwrite(0, 8'd0, 16'h0043);
        pulse(16'h8000, 2); idle(12);
        hread(1, 8'd94, "R5 base offset ch15");

        // R8 host write during busy ignored
        pulse(16'h0002, 2);
        while (m_phase == 0) @(negedge clk);
        host_en = 1; host_we = 1; host_space = 1; host_addr = 8'd200; host_wdata = 16'hDEAD;
        @(negedge clk);
        host_en = 0; host_we = 0;
        idle(10);
        hread(1, 8'd200, "R8 write during busy ignored");

        // final sweep of all memory
        idle(10);
        for (int w = 0; w < 128; w++) hread(1, 8'(w * 2), "R5 final memory");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule